// File: doc/BRIEF.md
# Task-File Status and Device Control Slice

This block is the status and control corner of an ATA-style task-file register set on a storage card. Device-side logic drives a set of condition inputs: busy, ready, write fault, seek complete, data request, corrected error and error. The block packs them into one status byte. The host can read that byte at two task-file offsets. The primary copy acknowledges a pending interrupt when read. The alternate copy returns the same byte with no side effect.

A single-cycle interrupt request from the device sets a pending flag. The flag reaches the host interrupt line only while the active-low interrupt-disable bit of the device control register is 0. The device control register shares its offset with the alternate status copy: a read there returns status and a write there updates control. Writes are accepted at any time, including while the device is busy. The soft-reset bit in that register is held as a level on an output for as long as it stays 1. After a soft reset, the status reports busy until the device side reports ready.

Top module: `tf_status_ctrl`

## Requirements
- R1: A status read returns bit 7 = busy, 6 = ready, 5 = write fault, 4 = seek complete, 3 = data request, 2 = corrected error, 0 = error, taken from the device inputs in the same cycle as the read. When no read is in progress, `host_rdata` is 0.
- R2: Status bit 1 always reads 0.
- R3: While bit 7 (busy) reads 1, bits 6 to 0 read 0.
- R4: A read at offset 14 (alternate) returns the same byte as a read at offset 7 (primary) under the same inputs.
- R5: A read at offset 7 clears the pending interrupt at that clock edge. A read at offset 14 leaves it pending.
- R6: If a device interrupt request and a primary status read occur in the same cycle, the interrupt stays pending.
- R7: A write to offset 14 with data bit 2 = 1 drives `soft_rst` high from the next cycle. `soft_rst` stays high until a write to offset 14 with bit 2 = 0. Such writes are accepted while the device reports busy.
- R8: Data bit 1 of a write to offset 14 is an interrupt disable, and `irq_enabled` is its inverse. While it is 1, `host_irq` is 0 but a request is still recorded. Clearing the bit to 0 while a request is pending raises `host_irq` again.
- R9: After hardware reset, `soft_rst` = 0, `irq_enabled` = 1 and `host_irq` = 0.
- R10: While `soft_rst` is 1, the pending interrupt is cleared, device requests are ignored and the status reads busy. After release, busy stays forced until `dev_rdy` is 1 at a clock edge.
- R11: Bits 7 to 3 and bit 0 of a control write are ignored. Writes to any offset other than 14 leave the control state unchanged. Reads at other offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| host_addr | input | ADDR_W | Task-file offset |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Status byte during a status read, else 0 |
| dev_busy | input | 1 | Device busy |
| dev_rdy | input | 1 | Device ready for a command |
| dev_wfault | input | 1 | Write fault |
| dev_seekdone | input | 1 | Seek complete |
| dev_drq | input | 1 | Data request |
| dev_corr | input | 1 | Corrected data error |
| dev_err | input | 1 | Previous command ended in error |
| dev_irq_req | input | 1 | Single-cycle interrupt request |
| host_irq | output | 1 | Gated interrupt to the host |
| soft_rst | output | 1 | Level-held soft-reset request |
| irq_enabled | output | 1 | High when the interrupt-disable bit is 0 |

## Verification
The hardest case to reach is the exact collision of a device interrupt request with a primary status read. A normal host sequence never places the two in the same cycle, so a dedicated task drives both strobes in one cycle. It then checks that the line stays high, and confirms with a second read that the flag was still live. The release from soft reset is also awkward to reach. The stimulus holds `dev_rdy` low across the release, checks that the forced busy persists, and then raises ready to watch the status fall through to the device inputs.

// File: rtl/tf_stat_pkg.sv
package tf_stat_pkg;
   localparam int STAT_W  = 8;
   localparam int ST_BUSY = 7;
   localparam int ST_RDY  = 6;
   localparam int ST_DWF  = 5;
   localparam int ST_DSC  = 4;
   localparam int ST_DRQ  = 3;
   localparam int ST_CORR = 2;
   localparam int ST_IDX  = 1;
   localparam int ST_ERR  = 0;

   typedef struct packed {
      logic busy;
      logic rdy;
      logic wfault;
      logic seekdone;
      logic drq;
      logic corr;
      logic err;
   } dev_cond_t;
endpackage

// File: rtl/tf_reg_decode.sv
module tf_reg_decode #(
   parameter int ADDR_W    = 4,
   parameter int PRI_OFFS  = 7,
   parameter int CTRL_OFFS = 14
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd,
   input  logic              wr,
   output logic              pri_rd,
   output logic              alt_rd,
   output logic              ctl_wr
);
   localparam logic [ADDR_W-1:0] PRI_A  = ADDR_W'(PRI_OFFS);
   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFFS);

   always_comb begin
      pri_rd = rd && (addr == PRI_A);
      alt_rd = rd && (addr == CTRL_A);
      ctl_wr = wr && (addr == CTRL_A);
   end
endmodule

// File: rtl/tf_devctl.sv
module tf_devctl #(
   parameter int DATA_W   = 8,
   parameter int SRST_BIT = 2,
   parameter int NIEN_BIT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr,
   input  logic [DATA_W-1:0] wdata,
   output logic              srst,
   output logic              nien
);
   logic unused_ignored_bits;
   assign unused_ignored_bits = ^wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         srst <= 1'b0;
         nien <= 1'b0;
      end else if (ctl_wr) begin
         srst <= wdata[SRST_BIT];
         nien <= wdata[NIEN_BIT];
      end
   end
endmodule

// File: rtl/tf_irq_track.sv
module tf_irq_track (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic pri_rd,
   input  logic srst,
   input  logic nien,
   output logic host_irq
);
   logic pend_q;
   logic pend_d;

   always_comb begin
      pend_d = pend_q;
      if (srst)        pend_d = 1'b0;
      else if (req)    pend_d = 1'b1;
      else if (pri_rd) pend_d = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= 1'b0;
      else        pend_q <= pend_d;
   end

   assign host_irq = pend_q & ~nien;
endmodule

// File: rtl/tf_status_fmt.sv
module tf_status_fmt
   import tf_stat_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter bit READ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  dev_cond_t         cond,
   input  logic              srst,
   input  logic              pri_rd,
   input  logic              alt_rd,
   output logic [DATA_W-1:0] rdata
);
   logic              hold_q;
   logic              busy_eff;
   logic [STAT_W-1:0] stat;
   logic [DATA_W-1:0] rd_word;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            hold_q <= 1'b0;
      else if (srst)         hold_q <= 1'b1;
      else if (cond.rdy)     hold_q <= 1'b0;
   end

   assign busy_eff = cond.busy | hold_q | srst;

   always_comb begin
      stat = '0;
      if (busy_eff) begin
         stat[ST_BUSY] = 1'b1;
      end else begin
         stat[ST_RDY]  = cond.rdy;
         stat[ST_DWF]  = cond.wfault;
         stat[ST_DSC]  = cond.seekdone;
         stat[ST_DRQ]  = cond.drq;
         stat[ST_CORR] = cond.corr;
         stat[ST_IDX]  = 1'b0;
         stat[ST_ERR]  = cond.err;
      end
      rd_word = (pri_rd || alt_rd) ? DATA_W'(stat) : '0;
   end

   generate
      if (READ_REG) begin : g_reg_rd
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rdata <= '0;
            else        rdata <= rd_word;
         end
      end else begin : g_comb_rd
         assign rdata = rd_word;
      end
   endgenerate
endmodule

// File: rtl/tf_status_ctrl.sv
module tf_status_ctrl
   import tf_stat_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter int DATA_W    = 8,
   parameter int PRI_OFFS  = 7,
   parameter int CTRL_OFFS = 14,
   parameter int SRST_BIT  = 2,
   parameter int NIEN_BIT  = 1,
   parameter bit READ_REG  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic              host_rd,
   input  logic              host_wr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   input  logic              dev_busy,
   input  logic              dev_rdy,
   input  logic              dev_wfault,
   input  logic              dev_seekdone,
   input  logic              dev_drq,
   input  logic              dev_corr,
   input  logic              dev_err,
   input  logic              dev_irq_req,
   output logic              host_irq,
   output logic              soft_rst,
   output logic              irq_enabled
);
   initial begin
      assert (DATA_W == STAT_W) else $error("DATA_W must equal the status width");
      assert (PRI_OFFS != CTRL_OFFS) else $error("offsets must differ");
      assert (PRI_OFFS < (1 << ADDR_W) && CTRL_OFFS < (1 << ADDR_W))
         else $error("offset exceeds address range");
      assert (SRST_BIT != NIEN_BIT && SRST_BIT < DATA_W && NIEN_BIT < DATA_W)
         else $error("control bit positions invalid");
   end

   logic      pri_rd, alt_rd, ctl_wr;
   logic      srst_q, nien_q;
   dev_cond_t cond;

   assign cond = '{busy: dev_busy, rdy: dev_rdy, wfault: dev_wfault,
                   seekdone: dev_seekdone, drq: dev_drq, corr: dev_corr,
                   err: dev_err};

   tf_reg_decode #(.ADDR_W(ADDR_W), .PRI_OFFS(PRI_OFFS), .CTRL_OFFS(CTRL_OFFS)) u_dec (
      .addr(host_addr), .rd(host_rd), .wr(host_wr),
      .pri_rd(pri_rd), .alt_rd(alt_rd), .ctl_wr(ctl_wr)
   );

   tf_devctl #(.DATA_W(DATA_W), .SRST_BIT(SRST_BIT), .NIEN_BIT(NIEN_BIT)) u_ctl (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .wdata(host_wdata),
      .srst(srst_q), .nien(nien_q)
   );

   tf_irq_track u_irq (
      .clk(clk), .rst_n(rst_n), .req(dev_irq_req), .pri_rd(pri_rd),
      .srst(srst_q), .nien(nien_q), .host_irq(host_irq)
   );

   tf_status_fmt #(.DATA_W(DATA_W), .READ_REG(READ_REG)) u_fmt (
      .clk(clk), .rst_n(rst_n), .cond(cond), .srst(srst_q),
      .pri_rd(pri_rd), .alt_rd(alt_rd), .rdata(host_rdata)
   );

   assign soft_rst    = srst_q;
   assign irq_enabled = ~nien_q;
endmodule

// File: rtl/tf_status_ctrl_chk.sv
module tf_status_ctrl_chk #(
   parameter int ADDR_W    = 4,
   parameter int DATA_W    = 8,
   parameter int PRI_OFFS  = 7,
   parameter int CTRL_OFFS = 14,
   parameter bit READ_REG  = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] host_addr,
   input logic              host_rd,
   input logic              host_wr,
   input logic [DATA_W-1:0] host_rdata,
   input logic              dev_irq_req,
   input logic              host_irq,
   input logic              soft_rst,
   input logic              irq_enabled
);
   localparam logic [ADDR_W-1:0] PRI_A  = ADDR_W'(PRI_OFFS);
   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFFS);

   logic ctl_write;
   assign ctl_write = host_wr && (host_addr == CTRL_A);

   a_r2_idx_zero: assert property (@(posedge clk) disable iff (!rst_n)
      host_rdata[1] == 1'b0);

   a_r3_busy_masks: assert property (@(posedge clk) disable iff (!rst_n)
      host_rdata[7] |-> (host_rdata[6:0] == '0));

   a_r5_pri_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && host_addr == PRI_A && !dev_irq_req) |=> !host_irq);

   a_r5_alt_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && host_addr == CTRL_A && !host_wr && host_irq && !soft_rst) |=> host_irq);

   a_r6_req_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_irq_req && !soft_rst && irq_enabled && !ctl_write) |=> host_irq);

   a_r7_srst_held: assert property (@(posedge clk) disable iff (!rst_n)
      (soft_rst && !ctl_write) |=> soft_rst);

   a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_enabled |-> !host_irq);

   a_r10_srst_clears: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> !host_irq);

   a_r11_ctl_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_write |=> ($stable(soft_rst) && $stable(irq_enabled)));

   generate
      if (!READ_REG) begin : g_comb_chk
         a_r10_busy_forced: assert property (@(posedge clk) disable iff (!rst_n)
            (soft_rst && host_rd && (host_addr == PRI_A || host_addr == CTRL_A))
            |-> host_rdata[7]);
      end
   endgenerate
endmodule

bind tf_status_ctrl tf_status_ctrl_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRI_OFFS(PRI_OFFS),
   .CTRL_OFFS(CTRL_OFFS), .READ_REG(READ_REG)
) u_chk (
   .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd(host_rd),
   .host_wr(host_wr), .host_rdata(host_rdata), .dev_irq_req(dev_irq_req),
   .host_irq(host_irq), .soft_rst(soft_rst), .irq_enabled(irq_enabled)
);

// File: tb/tf_status_ctrl_tb_top.sv
module tf_status_ctrl_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] host_addr = '0;
   logic       host_rd = 1'b0, host_wr = 1'b0;
   logic [7:0] host_wdata = '0;
   logic [7:0] host_rdata;
   logic       dev_busy = 0, dev_rdy = 0, dev_wfault = 0, dev_seekdone = 0;
   logic       dev_drq = 0, dev_corr = 0, dev_err = 0, dev_irq_req = 0;
   logic       host_irq, soft_rst, irq_enabled;

   int n_chk = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   tf_status_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd(host_rd),
      .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .dev_busy(dev_busy), .dev_rdy(dev_rdy), .dev_wfault(dev_wfault),
      .dev_seekdone(dev_seekdone), .dev_drq(dev_drq), .dev_corr(dev_corr),
      .dev_err(dev_err), .dev_irq_req(dev_irq_req), .host_irq(host_irq),
      .soft_rst(soft_rst), .irq_enabled(irq_enabled)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_stat(input logic busy, rdy, dwf, dsc, drq, corr, err);
      if (busy) return 8'h80;
      return {1'b0, rdy, dwf, dsc, drq, corr, 1'b0, err};
   endfunction

   task automatic rd(input logic [3:0] a, output logic [7:0] d);
      @(negedge clk);
      host_addr = a; host_rd = 1'b1;
      #1 d = host_rdata;
      @(negedge clk);
      host_rd = 1'b0;
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      host_addr = a; host_wdata = d; host_wr = 1'b1;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic irq_pulse();
      @(negedge clk);
      dev_irq_req = 1'b1;
      @(negedge clk);
      dev_irq_req = 1'b0;
   endtask

   task automatic set_dev(input logic [6:0] v);
      {dev_busy, dev_rdy, dev_wfault, dev_seekdone, dev_drq, dev_corr, dev_err} = v;
   endtask

   task automatic t_reset();
      logic [7:0] d;
      chk("R9 soft_rst", {7'd0, soft_rst}, 8'd0);
      chk("R9 irq_enabled", {7'd0, irq_enabled}, 8'd1);
      chk("R9 host_irq", {7'd0, host_irq}, 8'd0);
      chk("R1 idle rdata", host_rdata, 8'h00);
      rd(4'd7, d);
      chk("R1 all-zero status", d, 8'h00);
   endtask

   task automatic t_layout();
      logic [7:0] dp, da;
      logic [6:0] pats [4] = '{7'b0101011, 7'b0110100, 7'b0111111, 7'b0000001};
      foreach (pats[i]) begin
         set_dev(pats[i]);
         rd(4'd7, dp);
         rd(4'd14, da);
         chk("R1 layout", dp, exp_stat(pats[i][6], pats[i][5], pats[i][4],
                                      pats[i][3], pats[i][2], pats[i][1], pats[i][0]));
         chk("R4 alt equals primary", da, dp);
         chk("R2 bit1 zero", {7'd0, dp[1]}, 8'd0);
      end
   endtask

   task automatic t_busy_mask();
      logic [7:0] d;
      set_dev(7'b1111111);
      rd(4'd7, d);
      chk("R3 busy masks others", d, 8'h80);
      set_dev(7'b0);
   endtask

   task automatic t_irq_clear();
      logic [7:0] d;
      irq_pulse();
      chk("R5 pending raised", {7'd0, host_irq}, 8'd1);
      rd(4'd14, d);
      chk("R5 alt read keeps", {7'd0, host_irq}, 8'd1);
      rd(4'd7, d);
      chk("R5 primary read clears", {7'd0, host_irq}, 8'd0);
   endtask

   task automatic t_irq_collide();
      logic [7:0] d;
      irq_pulse();
      @(negedge clk);
      host_addr = 4'd7; host_rd = 1'b1; dev_irq_req = 1'b1;
      @(negedge clk);
      host_rd = 1'b0; dev_irq_req = 1'b0;
      chk("R6 request wins over read", {7'd0, host_irq}, 8'd1);
      rd(4'd7, d);
      chk("R6 later read clears", {7'd0, host_irq}, 8'd0);
   endtask

   task automatic t_nien();
      wr(4'd14, 8'h02);
      chk("R8 irq_enabled low", {7'd0, irq_enabled}, 8'd0);
      irq_pulse();
      chk("R8 line masked", {7'd0, host_irq}, 8'd0);
      wr(4'd14, 8'h00);
      chk("R8 reasserts on enable", {7'd0, host_irq}, 8'd1);
      wr(4'd14, 8'hF9);
      chk("R11 ignored bits srst", {7'd0, soft_rst}, 8'd0);
      chk("R11 ignored bits irq_en", {7'd0, irq_enabled}, 8'd1);
      chk("R11 pending untouched", {7'd0, host_irq}, 8'd1);
   endtask

   task automatic t_srst();
      logic [7:0] d;
      set_dev(7'b1000000);
      wr(4'd14, 8'h04);
      chk("R7 accepted while busy", {7'd0, soft_rst}, 8'd1);
      @(negedge clk);
      chk("R10 pending cleared", {7'd0, host_irq}, 8'd0);
      irq_pulse();
      repeat (5) @(negedge clk);
      chk("R7 level held", {7'd0, soft_rst}, 8'd1);
      set_dev(7'b0);
      rd(4'd7, d);
      chk("R10 busy during srst", d, 8'h80);
      wr(4'd14, 8'h00);
      chk("R7 released", {7'd0, soft_rst}, 8'd0);
      chk("R10 request ignored", {7'd0, host_irq}, 8'd0);
      rd(4'd7, d);
      chk("R10 busy until ready", d, 8'h80);
      set_dev(7'b0100000);
      rd(4'd7, d);
      chk("R10 ready after release", d, 8'h40);
   endtask

   task automatic t_other_addr();
      logic [7:0] d;
      wr(4'd7, 8'h06);
      chk("R11 wrong-offset srst", {7'd0, soft_rst}, 8'd0);
      chk("R11 wrong-offset irq_en", {7'd0, irq_enabled}, 8'd1);
      rd(4'd3, d);
      chk("R11 other offset reads 0", d, 8'h00);
   endtask

   initial begin
      #(200000 * 4);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_layout();
      t_busy_mask();
      t_irq_clear();
      t_irq_collide();
      t_nien();
      t_srst();
      t_other_addr();
      repeat (2) @(negedge clk);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule